// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Dual 80-bit Accumulators

This block multiplies two 32-bit operands and either returns a 32-bit slice of the product or combines the product with one of two 80-bit accumulators: a foreground and a background one. An 8-bit operation code comes with each operation. It says how each operand's sign is treated, whether the data is integer or fractional, whether to round, and where the result goes. The same code space also carries three housekeeping operations on an accumulator: saturate, round and clear.

A separate transfer port moves any one of the three sections of either accumulator to or from a 32-bit bus. The sections are low (bits 31..0), middle (bits 63..32) and high (bits 79..64). Three registered flags describe the last arithmetic result: negative, overflow and underflow. The number of upper bits that the overflow test checks depends on signedness and format.

Operation code layout: bits 7..6 are the group (00 housekeeping, 01 multiply, 10 multiply-add, 11 multiply-subtract). In the multiply groups, bit 5 marks y as signed and bit 4 marks x as signed. Bit 3 selects fractional format. Bit 2 writes the accumulator instead of the 32-bit output. Bit 1 selects the background accumulator (0 selects the foreground one). Bit 0 requests rounding. In group 00, bits 5..4 give the kind (01 clear, 10 round, 11 saturate), bit 3 is the format, bit 1 selects the accumulator and bit 0 marks the data as signed.

Top module: `mac80_unit`

## Requirements
- R1: A multiply (group 01) with bit 2 clear puts the product on `result_out`. Integer format takes product bits 31..0. Fractional format first shifts the product left by one and then takes bits 63..32. The accumulators are left unchanged.
- R2: Each operand is zero-extended when its sign bit (bit 5 for y, bit 4 for x) is 0, and sign-extended when it is 1. The result counts as signed when either operand is signed.
- R3: The rounding bit has an effect only in fractional format. There it adds 2^31 to the 80-bit result and clears bits 31..0. In integer format it has no effect.
- R4: With bit 2 set, all 80 bits of the accumulator chosen by bit 1 are written. Multiply-add writes acc+product, and multiply-subtract writes acc-product, into the same accumulator they read. The other accumulator is unchanged.
- R5: The overflow flag is set when the checked upper bits of the 80-bit result are not all zero, and, for a signed result, also not all one. The number of checked bits is 33 for signed fractional, 49 for signed integer, 32 for unsigned fractional and 48 for unsigned integer.
- R6: The underflow flag is set only for fractional results. It requires that bits 79..32 be all zero (or all one for a signed result) while bits 31..0 are nonzero. Integer results never set it.
- R7: The negative flag takes bit 79 of the result.
- R8: Saturate (kind 11) replaces an accumulator that overflows its format limit by the largest value that fits, or for a negative signed value by its two's complement lowest value. An accumulator that does not overflow is left unchanged. After a saturate the overflow and underflow flags are clear and the negative flag follows bit 79.
- R9: Round (kind 10) rounds the selected accumulator as in R3 when the format bit is 1, and leaves it unchanged when the format bit is 0.
- R10: Clear (kind 01) zeroes all 80 bits of the selected accumulator and clears all three flags.
- R11: Transfer select codes: 0000, 0001 and 0010 are foreground low, middle and high; 0100, 0101 and 0110 are background low, middle and high. A write to a high section takes bus bits 15..0. A read of a high section returns those 16 bits sign-extended to 32.
- R12: Every transfer clears all three flags. When an operation and a transfer arrive in the same cycle, the operation executes and the transfer is dropped.
- R13: `result_out`, `bus_out`, the flags and the accumulators all update at the first rising clock edge after the request is presented, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 8 | Operation code |
| x_in | input | 32 | X operand |
| y_in | input | 32 | Y operand |
| xfer_valid | input | 1 | Accumulator section transfer request |
| xfer_wr | input | 1 | 1 = bus to accumulator, 0 = accumulator to bus |
| xfer_sel | input | 4 | Section select code |
| bus_in | input | 32 | Data written into a section |
| result_out | output | 32 | 32-bit multiply result |
| bus_out | output | 32 | Section read data |
| flag_neg | output | 1 | Negative flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_unf | output | 1 | Underflow flag |

## Verification
Each result of this block is due exactly one rising edge after its request. This holds for the 32-bit product slice, the section read data, the flags and the accumulator contents. The bench presents every request just after a falling edge and withdraws it at the next falling edge. Results are read at that second falling edge, half a period after the updating edge. One test also reads `result_out` just before the edge, to confirm the new value has not yet appeared. Accumulator contents are observed only through read transfers issued after the operation under test. Because every transfer clears the flags, flag checks are made before any such read.

// File: rtl/mac80_unit.sv
module mac80_unit #(
  parameter int DW = 32,
  parameter int AW = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic          xfer_valid,
  input  logic          xfer_wr,
  input  logic [3:0]    xfer_sel,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] result_out,
  output logic [DW-1:0] bus_out,
  output logic          flag_neg,
  output logic          flag_ovf,
  output logic          flag_unf
);
  localparam int HW  = AW - 2*DW;
  localparam int PW  = 2*DW + 2;
  localparam int NSF = DW + 1;
  localparam int NUF = DW;
  localparam int NSI = AW - DW + 1;
  localparam int NUI = AW - DW;
  localparam logic [AW-1:0] HALF  = AW'(1) << (DW-1);
  localparam logic [AW-1:0] ONES  = {AW{1'b1}};
  localparam logic [AW-1:0] UMASK = ~(ONES >> (AW-DW));

  logic [AW-1:0] acc_fg, acc_bg;

  wire [1:0] grp    = op_code[7:6];
  wire [1:0] kind   = op_code[5:4];
  wire       is_mul = grp != 2'b00;
  wire       y_sgn  = op_code[5];
  wire       x_sgn  = op_code[4];
  wire       frac   = op_code[3];
  wire       to_acc = op_code[2];
  wire       acc_b  = op_code[1];
  wire       rnd    = op_code[0];
  wire       res_sgn = is_mul ? (x_sgn | y_sgn) : op_code[0];

  logic signed [DW:0]   xe, ye;
  logic signed [PW-1:0] prod;
  logic [AW-1:0] pext, pshift, acc_src, mac_v, rounded, v, tmask, lim, satv;
  logic          apply_rnd, ovf_c, unf_c, hi_zero, hi_ones;
  int unsigned   nchk;

  assign xe      = {x_sgn & x_in[DW-1], x_in};
  assign ye      = {y_sgn & y_in[DW-1], y_in};
  assign prod    = PW'(xe) * PW'(ye);
  assign pext    = AW'(prod);
  assign pshift  = frac ? (pext << 1) : pext;
  assign acc_src = acc_b ? acc_bg : acc_fg;

  always_comb begin
    case (grp)
      2'b01:   mac_v = pshift;
      2'b10:   mac_v = acc_src + pshift;
      2'b11:   mac_v = acc_src - pshift;
      default: mac_v = acc_src;
    endcase
  end

  assign apply_rnd = frac & (is_mul ? rnd : (kind == 2'b10));
  assign rounded   = mac_v + HALF;
  assign v         = apply_rnd ? {rounded[AW-1:DW], {DW{1'b0}}} : mac_v;

  assign nchk    = frac ? (res_sgn ? NSF : NUF) : (res_sgn ? NSI : NUI);
  assign lim     = ONES >> nchk;
  assign tmask   = ~lim;
  assign hi_zero = (v & tmask) == '0;
  assign hi_ones = (v & tmask) == tmask;
  assign ovf_c   = !(hi_zero || (res_sgn && hi_ones));
  assign unf_c   = frac && (v[DW-1:0] != '0) &&
                   (((v & UMASK) == '0) || (res_sgn && ((v & UMASK) == UMASK)));
  assign satv    = ovf_c ? ((res_sgn && v[AW-1]) ? ~lim : lim) : v;

  logic [AW-1:0] sec_acc, sec_new;
  logic [DW-1:0] sec_rd;
  wire           sec_ok = !xfer_sel[3] && (xfer_sel[1:0] != 2'b11);

  assign sec_acc = xfer_sel[2] ? acc_bg : acc_fg;

  always_comb begin
    sec_new = sec_acc;
    sec_rd  = '0;
    case (xfer_sel[1:0])
      2'b00: begin sec_new[DW-1:0]    = bus_in;         sec_rd = sec_acc[DW-1:0];    end
      2'b01: begin sec_new[2*DW-1:DW] = bus_in;         sec_rd = sec_acc[2*DW-1:DW]; end
      2'b10: begin sec_new[AW-1:2*DW] = bus_in[HW-1:0];
                   sec_rd = {{(DW-HW){sec_acc[AW-1]}}, sec_acc[AW-1:2*DW]}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_fg     <= '0;
      acc_bg     <= '0;
      result_out <= '0;
      bus_out    <= '0;
      flag_neg   <= 1'b0;
      flag_ovf   <= 1'b0;
      flag_unf   <= 1'b0;
    end else if (op_valid) begin
      if (is_mul) begin
        if (to_acc) begin
          if (acc_b) acc_bg <= v;
          else       acc_fg <= v;
        end else begin
          result_out <= frac ? v[2*DW-1:DW] : v[DW-1:0];
        end
        flag_neg <= v[AW-1];
        flag_ovf <= ovf_c;
        flag_unf <= unf_c;
      end else begin
        case (kind)
          2'b01: begin
            if (acc_b) acc_bg <= '0;
            else       acc_fg <= '0;
            flag_neg <= 1'b0;
            flag_ovf <= 1'b0;
            flag_unf <= 1'b0;
          end
          2'b10: begin
            if (acc_b) acc_bg <= v;
            else       acc_fg <= v;
            flag_neg <= v[AW-1];
            flag_ovf <= ovf_c;
            flag_unf <= unf_c;
          end
          2'b11: begin
            if (acc_b) acc_bg <= satv;
            else       acc_fg <= satv;
            flag_neg <= satv[AW-1];
            flag_ovf <= 1'b0;
            flag_unf <= 1'b0;
          end
          default: ;
        endcase
      end
    end else if (xfer_valid) begin
      if (xfer_wr) begin
        if (sec_ok) begin
          if (xfer_sel[2]) acc_bg <= sec_new;
          else             acc_fg <= sec_new;
        end
      end else begin
        bus_out <= sec_ok ? sec_rd : '0;
      end
      flag_neg <= 1'b0;
      flag_ovf <= 1'b0;
      flag_unf <= 1'b0;
    end
  end

  a_r10_clear_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !is_mul && kind == 2'b01 |=> !flag_neg && !flag_ovf && !flag_unf);

  a_r12_xfer_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && xfer_valid |=> !flag_neg && !flag_ovf && !flag_unf);

  a_r6_integer_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mul && !frac |=> !flag_unf);

  a_r6_unf_excludes_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_unf && flag_ovf));

  a_r8_saturate_drops_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !is_mul && kind == 2'b11 |=> !flag_ovf);

  a_r7_neg_tracks_fg: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mul && to_acc && !acc_b |=> flag_neg == acc_fg[AW-1]);

  a_r4_bg_kept_on_fg_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_mul && to_acc && !acc_b |=> $stable(acc_bg));
endmodule

// File: tb/tb_mac80_unit.sv
module tb_mac80_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = '0;
  logic [31:0] x_in = '0, y_in = '0;
  logic        xfer_valid = 1'b0, xfer_wr = 1'b0;
  logic [3:0]  xfer_sel = '0;
  logic [31:0] bus_in = '0;
  logic [31:0] result_out, bus_out;
  logic        flag_neg, flag_ovf, flag_unf;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;

  mac80_unit dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic [2:0] exp);
    check(tag, {29'd0, flag_neg, flag_ovf, flag_unf}, {29'd0, exp});
  endtask

  task automatic do_op(input logic [7:0] c, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; x_in = x; y_in = y;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_wr = 1'b1; xfer_sel = s; bus_in = d;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic rd_sec(input logic [3:0] s, output logic [31:0] d);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_wr = 1'b0; xfer_sel = s;
    @(negedge clk);
    xfer_valid = 1'b0;
    d = bus_out;
  endtask

  task automatic t_reset;
    check("R13 reset result", result_out, 32'h0);
    check("R13 reset bus", bus_out, 32'h0);
    flags("R13 reset flags", 3'b000);
  endtask

  task automatic t_signedness;
    do_op(8'h70, 32'hFFFF_FFFD, 32'd7);
    check("R1 signed int product", result_out, 32'hFFFF_FFEB);
    flags("R7 signed int flags", 3'b100);
    do_op(8'h40, 32'hFFFF_FFFF, 32'd2);
    check("R2 unsigned int product", result_out, 32'hFFFF_FFFE);
    flags("R5 unsigned int 48-bit overflow", 3'b010);
    do_op(8'h70, 32'hFFFF_FFFF, 32'd2);
    flags("R2 signed same bits no overflow", 3'b100);
    do_op(8'h50, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2 mixed sign product", result_out, 32'h0000_0001);
    flags("R5 signed int 49-bit overflow", 3'b110);
  endtask

  task automatic t_fraction;
    do_op(8'h48, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R1 unsigned frac high slice", result_out, 32'hFFFF_FFFC);
    flags("R5 unsigned frac overflow", 3'b010);
    do_op(8'h78, 32'd1, 32'd1);
    check("R1 tiny frac slice", result_out, 32'h0);
    flags("R6 frac underflow", 3'b001);
    do_op(8'h79, 32'd1, 32'h4000_0000);
    check("R3 frac round up", result_out, 32'h1);
    flags("R3 rounded flags", 3'b000);
    do_op(8'h78, 32'd1, 32'h4000_0000);
    check("R3 frac no round", result_out, 32'h0);
    flags("R6 unrounded underflow", 3'b001);
    do_op(8'h71, 32'd3, 32'd5);
    check("R3 round ignored for integer", result_out, 32'd15);
  endtask

  task automatic t_latency;
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'h70; x_in = 32'd9; y_in = 32'd9;
    #(CLK_P/2 - 1);
    check("R13 no change before edge", result_out, 32'd15);
    @(negedge clk);
    op_valid = 1'b0;
    check("R13 result after one edge", result_out, 32'd81);
  endtask

  task automatic t_accumulate;
    do_op(8'h14, 32'd0, 32'd0);
    do_op(8'h7C, 32'h4000_0000, 32'h4000_0000);
    flags("R5 signed frac 33-bit overflow", 3'b010);
    do_op(8'hB4, 32'd10, 32'd20);
    rd_sec(4'b0000, rd);
    check("R4 multiply-add fg low", rd, 32'd200);
    rd_sec(4'b0001, rd);
    check("R4 fg middle", rd, 32'h2000_0000);
    do_op(8'h16, 32'd0, 32'd0);
    flags("R10 clear flags", 3'b000);
    do_op(8'hF6, 32'd2, 32'd3);
    flags("R7 negative after subtract", 3'b100);
    rd_sec(4'b0100, rd);
    check("R4 multiply-sub bg low", rd, 32'hFFFF_FFFA);
    flags("R12 read clears flags", 3'b000);
    rd_sec(4'b0110, rd);
    check("R11 bg high sign-extended", rd, 32'hFFFF_FFFF);
    rd_sec(4'b0000, rd);
    check("R4 fg untouched by bg ops", rd, 32'd200);
  endtask

  task automatic t_transfer;
    wr(4'b0101, 32'h1234_5678);
    rd_sec(4'b0101, rd);
    check("R11 bg middle write/read", rd, 32'h1234_5678);
    do_op(8'h14, 32'd0, 32'd0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'h70; x_in = 32'd1; y_in = 32'd1;
    xfer_valid = 1'b1; xfer_wr = 1'b1; xfer_sel = 4'b0000; bus_in = 32'hDEAD;
    @(negedge clk);
    op_valid = 1'b0; xfer_valid = 1'b0;
    check("R12 op wins result", result_out, 32'd1);
    rd_sec(4'b0000, rd);
    check("R12 collided transfer dropped", rd, 32'h0);
  endtask

  task automatic t_saturate;
    do_op(8'h16, 32'd0, 32'd0);
    wr(4'b0110, 32'h0000_0001);
    do_op(8'h37, 32'd0, 32'd0);
    flags("R8 saturate flags positive", 3'b000);
    rd_sec(4'b0100, rd);
    check("R8 positive clamp low", rd, 32'h7FFF_FFFF);
    rd_sec(4'b0101, rd);
    check("R8 positive clamp middle", rd, 32'h0);
    wr(4'b0110, 32'h0000_8000);
    do_op(8'h37, 32'd0, 32'd0);
    flags("R8 saturate flags negative", 3'b100);
    rd_sec(4'b0100, rd);
    check("R8 negative clamp low", rd, 32'h8000_0000);
    rd_sec(4'b0101, rd);
    check("R8 negative clamp middle", rd, 32'hFFFF_FFFF);
    do_op(8'h16, 32'd0, 32'd0);
    wr(4'b0100, 32'h0000_0055);
    do_op(8'h37, 32'd0, 32'd0);
    rd_sec(4'b0100, rd);
    check("R8 in-range value kept", rd, 32'h55);
  endtask

  task automatic t_round_clear;
    do_op(8'h14, 32'd0, 32'd0);
    wr(4'b0000, 32'h8000_0000);
    wr(4'b0001, 32'h0000_0005);
    do_op(8'h25, 32'd0, 32'd0);
    rd_sec(4'b0000, rd);
    check("R9 integer round leaves acc", rd, 32'h8000_0000);
    do_op(8'h2D, 32'd0, 32'd0);
    flags("R9 round flags", 3'b000);
    rd_sec(4'b0001, rd);
    check("R9 rounded middle", rd, 32'h6);
    rd_sec(4'b0000, rd);
    check("R9 rounded low cleared", rd, 32'h0);
    wr(4'b0010, 32'h0000_ABCD);
    do_op(8'h14, 32'd0, 32'd0);
    rd_sec(4'b0010, rd);
    check("R10 clear zeroes high", rd, 32'h0);
    rd_sec(4'b0001, rd);
    check("R10 clear zeroes middle", rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_signedness;
    t_fraction;
    t_latency;
    t_accumulate;
    t_transfer;
    t_saturate;
    t_round_clear;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule